// File: doc/BRIEF.md
# Two-Way Set-Associative Read/Write Cache

This block sits between a processor-side request port and a slower word-wide memory port. It keeps recently used words in a store with two ways per set and one word per block. The low bits of each word address pick a set, and the bits above them are kept as the tag. Both ways of the selected set are compared in parallel. A read that hits returns its data in the cycle the request is presented. A read that misses stalls the requester, fetches the word from memory and installs it in the set.

Writes are write-through. Every write goes to memory. A write that hits also refreshes the cached copy, and a write that misses leaves the cache contents alone. For the victim on a read miss, the block takes an empty way if the set has one. Otherwise it takes the way that a per-set recency bit marks as least recently used. Two counters record how many requests hit and how many missed, so a known access trace can be checked against its expected miss count.

Top module: `cache2w`

## Requirements
- R1: The set index is `cpu_addr[SET_W-1:0]` and the tag is the remaining upper address bits. Addresses that share the low bits compete for the same two ways. Addresses in other sets are not disturbed.
- R2: A lookup compares the tags of both ways of the selected set, and at most one way reports a hit.
- R3: Reset clears every valid bit, so the first access to any address after reset is a miss.
- R4: A read miss fills an invalid way of the set if one exists, way 0 before way 1. If both ways are valid, it replaces the way marked least recently used.
- R5: Every read hit, write hit and fill sets the set's recency bit to point at the way that was not just used.
- R6: A read hit raises `cpu_ready` in the same cycle as `cpu_valid`. It returns the cached word on `cpu_rdata` and makes no memory request.
- R7: A read miss raises `mem_req` with `mem_we`=0 in the following cycle and holds it until `mem_ack`. `cpu_ready` rises in the `mem_ack` cycle with `cpu_rdata` equal to `mem_rdata`, and the word is installed.
- R8: Every write raises `mem_req` with `mem_we`=1 and completes with `cpu_ready` in the `mem_ack` cycle. A write hit updates the cached word. A write miss installs nothing, so a later read of that address still misses.
- R9: `hit_cnt` and `miss_cnt` are zero after reset. Each accepted request adds one to exactly one of them, according to its lookup result.
- R10: With two sets, the word sequence 0, 8, 0, 6, 8 of reads produces four misses and one hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Request present; held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory access done (read data valid) |
| mem_rdata | input | DATA_W | Memory read data |
| hit_cnt | output | CNT_W | Number of hits since reset |
| miss_cnt | output | CNT_W | Number of misses since reset |

## Verification
A wrong valid, tag or recency bit shows up at the ports as a change in timing. A read that should complete in its first cycle instead waits out the memory latency, or the reverse, and `hit_cnt` or `miss_cnt` drifts from a reference count at once. A wrong data word shows on `cpu_rdata` at the next read hit to that address. A wrong victim choice usually surfaces only on the next revisit of the evicted address, so traces with heavy reuse of a few sets are replayed against a bench-side model of the set contents.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_t;

    // Victim choice: empty way 0, then empty way 1, then the LRU way.
    function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return lru;
    endfunction

endpackage

// File: rtl/cache2w_ways.sv
module cache2w_ways #(
    parameter int SET_W  = 3,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic [1:0]        lk_hit,
    output logic [1:0]        lk_vld,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [SET_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << SET_W;

    logic [DATA_W-1:0] way_data [2];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]   vld_q;
        logic [TAG_W-1:0]  tag_q [SETS];
        logic [DATA_W-1:0] dat_q [SETS];

        always_ff @(posedge clk) begin
            if (rst)
                vld_q <= '0;
            else if (wr_en && wr_way == 1'(w))
                vld_q[wr_idx] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                tag_q[wr_idx] <= wr_tag;
                dat_q[wr_idx] <= wr_data;
            end
        end

        assign lk_vld[w]   = vld_q[lk_idx];
        assign lk_hit[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        assign way_data[w] = dat_q[lk_idx];
    end

    assign lk_data = lk_hit[1] ? way_data[1] : way_data[0];

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit));

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int SET_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_idx,
    output logic             lru_way,
    input  logic             touch,
    input  logic [SET_W-1:0] touch_idx,
    input  logic             touch_way
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst)
            lru_q <= '0;
        else if (touch)
            lru_q[touch_idx] <= ~touch_way;
    end

    assign lru_way = lru_q[rd_idx];

    // R5
    lru_flip_chk: assert property (@(posedge clk) disable iff (rst)
        touch |=> (lru_q[$past(touch_idx)] != $past(touch_way)));

endmodule

// File: rtl/cache2w.sv
module cache2w
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SET_W  = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    localparam int TAG_W = ADDR_W - SET_W;

    ctl_state_t state_q, state_d;
    logic       victim_q;

    logic [SET_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [1:0]        lk_hit, lk_vld;
    logic [DATA_W-1:0] lk_data;
    logic              any_hit, hit_way, lru_way;

    logic              wr_en, wr_way, touch, touch_way;
    logic [DATA_W-1:0] wr_data;
    logic              cnt_hit, cnt_miss;

    assign idx     = cpu_addr[SET_W-1:0];
    assign tag     = cpu_addr[ADDR_W-1:SET_W];
    assign any_hit = |lk_hit;
    assign hit_way = lk_hit[1];

    cache2w_ways #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ways (
        .clk(clk), .rst(rst),
        .lk_idx(idx), .lk_tag(tag),
        .lk_hit(lk_hit), .lk_vld(lk_vld), .lk_data(lk_data),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(idx),
        .wr_tag(tag), .wr_data(wr_data)
    );

    cache2w_lru #(.SET_W(SET_W)) u_lru (
        .clk(clk), .rst(rst),
        .rd_idx(idx), .lru_way(lru_way),
        .touch(touch), .touch_idx(idx), .touch_way(touch_way)
    );

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = lk_data;
        wr_en     = 1'b0;
        wr_way    = hit_way;
        wr_data   = cpu_wdata;
        touch     = 1'b0;
        touch_way = hit_way;
        cnt_hit   = 1'b0;
        cnt_miss  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (cpu_we) begin
                        state_d = ST_WRITE;
                        if (any_hit) begin
                            wr_en   = 1'b1;
                            touch   = 1'b1;
                            cnt_hit = 1'b1;
                        end else begin
                            cnt_miss = 1'b1;
                        end
                    end else if (any_hit) begin
                        cpu_ready = 1'b1;
                        touch     = 1'b1;
                        cnt_hit   = 1'b1;
                    end else begin
                        state_d  = ST_FILL;
                        cnt_miss = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    wr_en     = 1'b1;
                    wr_way    = victim_q;
                    wr_data   = mem_rdata;
                    touch     = 1'b1;
                    touch_way = victim_q;
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                    state_d   = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            victim_q <= 1'b0;
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                victim_q <= pick_victim(lk_vld, lru_way);
            if (cnt_hit)
                hit_cnt <= hit_cnt + 1'b1;
            if (cnt_miss)
                miss_cnt <= miss_cnt + 1'b1;
        end
    end

    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

    // R8
    mem_write_src_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (cpu_valid && cpu_we));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_valid) |=>
            ({1'b0, hit_cnt} + {1'b0, miss_cnt}) ==
            ($past({1'b0, hit_cnt} + {1'b0, miss_cnt}) + 1'b1));

    // R9
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_IDLE && cpu_valid) |=> ($stable(hit_cnt) && $stable(miss_cnt)));

endmodule

// File: tb/cache2w_tb.sv
module cache2w_tb;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int SET_W  = 1;
    localparam int CNT_W  = 16;
    localparam int LAT    = 3;
    localparam int NSETS  = 1 << SET_W;
    localparam int TAG_W  = ADDR_W - SET_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [CNT_W-1:0]  hit_cnt, miss_cnt;

    always #5 clk = ~clk;

    cache2w #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    // Fixed-latency memory
    logic [DATA_W-1:0] mem [1 << ADDR_W];
    int lat_cnt;
    assign mem_ack   = mem_req && (lat_cnt == LAT - 1);
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (rst || mem_ack) lat_cnt <= 0;
        else if (mem_req)   lat_cnt <= lat_cnt + 1;
        if (!rst && mem_ack && mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Reference model of set contents
    bit               m_vld [NSETS][2];
    logic [TAG_W-1:0] m_tag [NSETS][2];
    bit               m_lru [NSETS];
    int               m_hits = 0, m_misses = 0;
    int               n_chk = 0, n_fail = 0;

    function automatic bit model_access(bit we, logic [ADDR_W-1:0] a);
        int s;
        bit hit, way, vic;
        logic [TAG_W-1:0] t;
        s = int'(a[SET_W-1:0]);
        t = a[ADDR_W-1:SET_W];
        hit = 1'b0; way = 1'b0;
        for (int w = 0; w < 2; w++)
            if (m_vld[s][w] && m_tag[s][w] == t) begin hit = 1'b1; way = w[0]; end
        if (hit) begin
            m_lru[s] = !way;
            m_hits++;
        end else begin
            m_misses++;
            if (!we) begin
                vic = !m_vld[s][0] ? 1'b0 : (!m_vld[s][1] ? 1'b1 : m_lru[s]);
                m_vld[s][vic] = 1'b1;
                m_tag[s][vic] = t;
                m_lru[s] = !vic;
            end
        end
        return hit;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input string req,
                          output bit was_hit);
        bit exp_hit, saw_req;
        int cyc, exp_cyc;
        logic [DATA_W-1:0] exp_d, got;
        exp_hit = model_access(we, a);
        exp_d   = mem[a];
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        saw_req = mem_req;
        cyc = 0;
        while (!cpu_ready && cyc < 50) begin
            @(negedge clk); #1; cyc++;
        end
        got = cpu_rdata;
        exp_cyc = (exp_hit && !we) ? 0 : LAT;
        check(req, cyc == exp_cyc, cyc, exp_cyc);
        if (!we) begin
            check(req, got == exp_d, int'(got), int'(exp_d));
            if (exp_hit) check(req, !saw_req, int'(saw_req), 0);
        end
        was_hit = (cyc == 0);
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit h;
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = DATA_W'(i * 37 + 5);
        for (int s = 0; s < NSETS; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R3 / R9: reset state
        check("R9", hit_cnt == 0 && miss_cnt == 0, int'(hit_cnt) + int'(miss_cnt), 0);
        check("R3", !cpu_ready && !mem_req, int'(cpu_ready), 0);

        // R10 trace 0,8,0,6,8 (all in set 0)
        access(1'b0, 6'd0, '0, "R3", h);  // cold miss
        access(1'b0, 6'd8, '0, "R4", h);  // fills empty way 1
        access(1'b0, 6'd0, '0, "R6", h);  // hit
        access(1'b0, 6'd6, '0, "R5", h);  // evicts 8 (LRU)
        access(1'b0, 6'd8, '0, "R4", h);  // evicts 0
        #1;
        check("R10", miss_cnt == 4, int'(miss_cnt), 4);
        check("R10", hit_cnt == 1, int'(hit_cnt), 1);

        // R1: set 1 traffic leaves set 0 intact
        access(1'b0, 6'd1, '0, "R1", h);
        access(1'b0, 6'd3, '0, "R1", h);
        access(1'b0, 6'd8, '0, "R1", h);  // still a hit in set 0
        access(1'b0, 6'd1, '0, "R1", h);

        // R8: write miss does not allocate; write hit updates cached word
        access(1'b1, 6'd20, 16'hBEEF, "R8", h);
        access(1'b0, 6'd20, '0, "R8", h);  // must miss, returns written word
        access(1'b1, 6'd20, 16'h1234, "R8", h);  // hit
        access(1'b0, 6'd20, '0, "R8", h);  // hit with new data

        // Random mix over a small address range to force reuse
        for (int i = 0; i < 400; i++) begin
            bit we;
            logic [ADDR_W-1:0] a;
            we = ($urandom % 4) == 0;
            a  = ADDR_W'($urandom % 12);
            access(we, a, DATA_W'($urandom), we ? "R8" : "R7", h);
        end
        #1;
        check("R9", int'(hit_cnt) == m_hits, int'(hit_cnt), m_hits);
        check("R9", int'(miss_cnt) == m_misses, int'(miss_cnt), m_misses);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule